// File: doc/BRIEF.md
# Three-Level Bridge State Encoder

This block turns a signed output level for one full-bridge cell into the eight gate commands of its two legs. Each leg is a three-level neutral-point-clamped leg of four series switches, and each leg sits at +1, 0 or -1. The level the cell produces is leg A's state minus leg B's state, so the level range is -2 to +2. Nine leg-state pairs map onto these five levels.

Levels ±2 each have one pair. Level +1 and level -1 each have two pairs, and each of those pairs works on only one of the two series DC capacitors. The encoder uses these two pairs to move charge between the capacitors. It decides from two single-bit comparator results: which capacitor is higher, and the direction of the cell current.

Level 0 has three pairs, and none of them moves capacitor energy. The encoder picks the one that needs the fewest switch changes from the pair already applied. The gate outputs are registered and change only on the strobe that marks the start of a switching period. A level outside ±2 puts both legs at 0 and raises an error flag.

Top module: `npc_bridge_encoder`

## Requirements
- R1: While reset is asserted and after reset until the first strobe, both legs are in state 0 (gate_a = gate_b = 4'b0110) and level_err is 0.
- R2: The four gate bits of each leg, with bit 0 driving the outermost upper switch and bit 3 the outermost lower switch, are 4'b0011 for leg state +1 (switches 1 and 2 closed), 4'b0110 for state 0 (switches 2 and 3 closed) and 4'b1100 for state -1 (switches 3 and 4 closed). No other pattern ever appears.
- R3: On a strobe with level +2 the next outputs are A=+1, B=-1. On a strobe with level -2 they are A=-1, B=+1.
- R4: On a strobe with level +1, the block uses the upper-capacitor pair (A=+1, B=0) when cap_upper_hi equals cur_out. Otherwise it uses the lower-capacitor pair (A=0, B=-1).
- R5: On a strobe with level -1, the block uses the upper-capacitor pair (A=0, B=+1) when cap_upper_hi equals cur_out. Otherwise it uses the lower-capacitor pair (A=-1, B=0).
- R6: On a strobe with level 0, both legs take the state leg A held before the strobe. An existing zero pair is therefore kept unchanged.
- R7: On a strobe with level +3, -3 or -4 (3-bit two's complement), both legs go to state 0 and level_err becomes 1. level_err returns to 0 on the next strobe that carries an in-range level.
- R8: In a cycle without a strobe, gate_a, gate_b and level_err keep their values, whatever the other inputs do.
- R9: After any strobe with an in-range level, leg A's state minus leg B's state equals the level that was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_stb | input | 1 | One-cycle strobe that starts a switching period; the inputs are sampled on it |
| level_in | input | 3 | Signed requested cell level, two's complement |
| cap_upper_hi | input | 1 | 1 when the upper capacitor voltage is above the lower one |
| cur_out | input | 1 | 1 when the cell current flows in the power-out direction |
| gate_a | output | 4 | Gate commands of leg A, bit 0 = switch 1 |
| gate_b | output | 4 | Gate commands of leg B, bit 0 = switch 1 |
| level_err | output | 1 | Last sampled level was outside -2..+2 |

## Verification
The assertions assume that the comparator bits and the level are synchronous to the clock and settled at the sampling edge. No metastable or glitching values reach the encoder. The bench changes every input half a period away from the rising edge, so this assumption holds. The bench also issues strobes at irregular intervals, with the side inputs changing between strobes. It drives every 3-bit level value, including the three out-of-range codes, and all four combinations of capacitor and current bits.

// File: rtl/npc_enc_pkg.sv
package npc_enc_pkg;

  // State of one three-level leg
  typedef enum logic [1:0] {
    LEG_NEG  = 2'd0,
    LEG_ZERO = 2'd1,
    LEG_POS  = 2'd2
  } leg_t;

  localparam int unsigned LEGS       = 2;
  localparam int unsigned SW_PER_LEG = 4;

endpackage

// File: rtl/npc_pair_select.sv
module npc_pair_select
  import npc_enc_pkg::*;
#(
  parameter int unsigned LVL_W = 3
) (
  input  logic signed [LVL_W-1:0] level,
  input  logic                    cap_upper_hi,
  input  logic                    cur_out,
  input  leg_t                    prev_a,
  output leg_t                    nxt_a,
  output leg_t                    nxt_b,
  output logic                    bad
);

  localparam logic signed [LVL_W-1:0] L_P2 = LVL_W'(2);
  localparam logic signed [LVL_W-1:0] L_P1 = LVL_W'(1);
  localparam logic signed [LVL_W-1:0] L_Z  = LVL_W'(0);
  localparam logic signed [LVL_W-1:0] L_M1 = LVL_W'(-1);
  localparam logic signed [LVL_W-1:0] L_M2 = LVL_W'(-2);

  logic use_upper;

  // Work on the higher capacitor when current flows out, on the other one otherwise
  assign use_upper = (cap_upper_hi == cur_out);

  always_comb begin
    nxt_a = LEG_ZERO;
    nxt_b = LEG_ZERO;
    bad   = 1'b0;
    case (level)
      L_P2: begin
        nxt_a = LEG_POS;
        nxt_b = LEG_NEG;
      end
      L_M2: begin
        nxt_a = LEG_NEG;
        nxt_b = LEG_POS;
      end
      L_P1: begin
        nxt_a = use_upper ? LEG_POS  : LEG_ZERO;
        nxt_b = use_upper ? LEG_ZERO : LEG_NEG;
      end
      L_M1: begin
        nxt_a = use_upper ? LEG_ZERO : LEG_NEG;
        nxt_b = use_upper ? LEG_POS  : LEG_ZERO;
      end
      L_Z: begin
        // Both legs follow leg A: only leg B moves, or nothing moves
        nxt_a = prev_a;
        nxt_b = prev_a;
      end
      default: begin
        bad = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/npc_leg_driver.sv
module npc_leg_driver
  import npc_enc_pkg::*;
(
  input  leg_t                  state,
  output logic [SW_PER_LEG-1:0] gates
);

  always_comb begin
    case (state)
      LEG_POS:  gates = 4'b0011;
      LEG_NEG:  gates = 4'b1100;
      default:  gates = 4'b0110;
    endcase
  end

endmodule

// File: rtl/npc_bridge_encoder.sv
module npc_bridge_encoder
  import npc_enc_pkg::*;
#(
  parameter int unsigned LVL_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    period_stb,
  input  logic signed [LVL_W-1:0] level_in,
  input  logic                    cap_upper_hi,
  input  logic                    cur_out,
  output logic [SW_PER_LEG-1:0]   gate_a,
  output logic [SW_PER_LEG-1:0]   gate_b,
  output logic                    level_err
);

  leg_t leg_q [LEGS];
  leg_t leg_d [LEGS];
  leg_t sel   [LEGS];
  logic err_q, err_d, sel_bad;
  logic [SW_PER_LEG-1:0] gates [LEGS];

  npc_pair_select #(.LVL_W(LVL_W)) u_sel (
    .level        (level_in),
    .cap_upper_hi (cap_upper_hi),
    .cur_out      (cur_out),
    .prev_a       (leg_q[0]),
    .nxt_a        (sel[0]),
    .nxt_b        (sel[1]),
    .bad          (sel_bad)
  );

  // Next state: load on strobe, hold otherwise
  always_comb begin
    err_d = err_q;
    for (int i = 0; i < LEGS; i++) leg_d[i] = leg_q[i];
    if (period_stb) begin
      err_d = sel_bad;
      for (int i = 0; i < LEGS; i++) leg_d[i] = sel[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      for (int i = 0; i < LEGS; i++) leg_q[i] <= LEG_ZERO;
    end else begin
      err_q <= err_d;
      for (int i = 0; i < LEGS; i++) leg_q[i] <= leg_d[i];
    end
  end

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    npc_leg_driver u_drv (
      .state (leg_q[g]),
      .gates (gates[g])
    );
  end

  assign gate_a    = gates[0];
  assign gate_b    = gates[1];
  assign level_err = err_q;

endmodule

// File: rtl/npc_bridge_encoder_chk.sv
module npc_bridge_encoder_chk #(
  parameter int unsigned LVL_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    period_stb,
  input logic signed [LVL_W-1:0] level_in,
  input logic [3:0]              gate_a,
  input logic [3:0]              gate_b,
  input logic                    level_err
);

  function automatic int leg_val(input logic [3:0] g);
    if (g == 4'b0011) return 1;
    if (g == 4'b1100) return -1;
    return 0;
  endfunction

  logic in_range;
  assign in_range = (level_in <= LVL_W'(2)) && (level_in >= LVL_W'(-2));

  // R2
  legal_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_a == 4'b0011 || gate_a == 4'b0110 || gate_a == 4'b1100) &&
    (gate_b == 4'b0011 || gate_b == 4'b0110 || gate_b == 4'b1100));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_stb |=> $stable(gate_a) && $stable(gate_b) && $stable(level_err));

  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_err |-> (gate_a == 4'b0110 && gate_b == 4'b0110));

  // R3
  full_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_stb && level_in == LVL_W'(2)) |=> (gate_a == 4'b0011 && gate_b == 4'b1100));

  // R6
  zero_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_stb && level_in == LVL_W'(0)) |=> (gate_a == gate_b && $stable(gate_a)));

  // R9
  level_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_stb && in_range) |=>
      (leg_val(gate_a) - leg_val(gate_b) == int'($past(level_in)) && !level_err));

endmodule

bind npc_bridge_encoder npc_bridge_encoder_chk #(.LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .period_stb (period_stb),
  .level_in   (level_in),
  .gate_a     (gate_a),
  .gate_b     (gate_b),
  .level_err  (level_err)
);

// File: tb/npc_bridge_encoder_test.sv
`timescale 1ns/1ps
module npc_bridge_encoder_test;

  logic clk = 1'b0;
  logic rst_n;
  logic period_stb;
  logic signed [2:0] level_in;
  logic cap_upper_hi, cur_out;
  logic [3:0] gate_a, gate_b;
  logic level_err;

  int checks = 0;
  int errors = 0;
  int ref_a = 0, ref_b = 0;
  bit ref_err = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;

  npc_bridge_encoder uut (
    .clk(clk), .rst_n(rst_n), .period_stb(period_stb), .level_in(level_in),
    .cap_upper_hi(cap_upper_hi), .cur_out(cur_out),
    .gate_a(gate_a), .gate_b(gate_b), .level_err(level_err)
  );

  function automatic logic [3:0] pat(input int v);
    if (v == 1) return 4'b0011;
    if (v == -1) return 4'b1100;
    return 4'b0110;
  endfunction

  task automatic compare();
    logic [3:0] ea, eb;
    ea = pat(ref_a);
    eb = pat(ref_b);
    checks++;
    if (gate_a !== ea || gate_b !== eb || level_err !== ref_err) begin
      errors++;
      $display("FAIL %s: gate_a=%b gate_b=%b err=%b expected gate_a=%b gate_b=%b err=%b",
               tag, gate_a, gate_b, level_err, ea, eb, ref_err);
    end
    checks++;
    if (!(gate_a inside {4'b0011, 4'b0110, 4'b1100}) ||
        !(gate_b inside {4'b0011, 4'b0110, 4'b1100})) begin
      errors++;
      $display("FAIL R2: gate_a=%b gate_b=%b expected a legal leg pattern", gate_a, gate_b);
    end
  endtask

  // Apply one clock of stimulus, update the model, compare at the next low phase
  task automatic step(input bit stb, input int lvl, input bit cap, input bit cur);
    bit up;
    period_stb   = stb;
    level_in     = 3'(lvl);
    cap_upper_hi = cap;
    cur_out      = cur;
    up = (cap == cur);
    if (!stb) tag = "R8";
    else if (lvl == 2 || lvl == -2) tag = "R3";
    else if (lvl == 1) tag = "R4";
    else if (lvl == -1) tag = "R5";
    else if (lvl == 0) tag = "R6";
    else tag = "R7";
    @(posedge clk);
    if (stb) begin
      ref_err = 1'b0;
      case (lvl)
        2:  begin ref_a = 1;  ref_b = -1; end
        -2: begin ref_a = -1; ref_b = 1;  end
        1:  begin ref_a = up ? 1 : 0;  ref_b = up ? 0 : -1; end
        -1: begin ref_a = up ? 0 : -1; ref_b = up ? 1 : 0;  end
        0:  begin ref_b = ref_a; end
        default: begin ref_a = 0; ref_b = 0; ref_err = 1'b1; end
      endcase
    end
    @(negedge clk);
    compare();
  endtask

  initial begin : watchdog
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    period_stb = 1'b0;
    level_in = 3'sd0;
    cap_upper_hi = 1'b0;
    cur_out = 1'b0;
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    compare();

    // R3 full levels, R9 differences
    step(1, 2, 0, 0);
    step(1, -2, 1, 1);
    // R6 zero after -2 keeps leg A at -1
    step(1, 0, 0, 1);
    step(1, 0, 1, 1);
    // R4 all four comparator combinations
    step(1, 1, 1, 1);
    step(1, 1, 0, 1);
    step(1, 1, 1, 0);
    step(1, 1, 0, 0);
    // R5 all four combinations
    step(1, -1, 1, 1);
    step(1, -1, 0, 1);
    step(1, -1, 1, 0);
    step(1, -1, 0, 0);
    // R8 inputs move without a strobe
    step(0, 2, 1, 0);
    step(0, -4, 0, 1);
    // R7 out of range codes, then recovery
    step(1, 3, 0, 0);
    step(0, 1, 1, 1);
    step(1, -3, 1, 0);
    step(1, -4, 0, 1);
    step(1, 2, 0, 0);
    step(1, 0, 1, 0);
    step(1, 3, 1, 1);
    step(1, 0, 0, 0);

    // Mixed run with irregular strobes
    for (int k = 0; k < 3000; k++) begin
      step(($urandom_range(0, 2) == 0), int'($urandom_range(0, 7)) - 4,
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule